// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block turns one internal operand request of 1 to 4 bytes, placed at any byte address, into the sequence of external bus cycles that a slave of unknown width needs. The slave reports its port width (8, 16 or 32 bits) in the same two-bit acknowledge that ends each cycle. The controller therefore decides after every cycle how many bytes moved, where the next cycle starts and how many bytes remain. No cycle count is fixed in advance.

Operands use big-endian order. The byte at the lowest address is the most significant byte of the operand, and request and result data sit right-justified in a 32-bit word. Reads are assembled from the responding port's lanes into a result word. Writes are laid out so that every possible port width finds its next byte on the lanes it decodes. A one-clock `done` pulse marks the end of an operand.

Top module: `dyn_bus_sizer`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_as`, `bus_ds`, `bus_ecs`, `bus_ocs` and `done` are 0.
- R2: While a cycle is active, `bus_siz` gives the operand bytes still to move: 01 = 1, 10 = 2, 11 = 3, 00 = 4. `req_siz` uses the same encoding.
- R3: `bus_ack` 00 reports a 32-bit port, 01 a 16-bit port and 10 an 8-bit port. 11 inserts a wait state, during which `bus_addr`, `bus_siz` and `bus_dout` hold steady.
- R4: Each acknowledged cycle moves min(remaining, P - (address mod P)) bytes, where P is the port width in bytes. The address then advances by that count and the remaining count drops by it, until no bytes remain.
- R5: `bus_ecs` is high for exactly the first clock of every bus cycle. `bus_ocs` is high only on that clock of the first cycle of an operand.
- R6: `bus_as` and `bus_ds` rise together when a cycle starts and stay high until the acknowledge is sampled. They are low for at least one clock before the next cycle starts.
- R7: On a read, byte k of the returned lanes is taken from lane `31-8*L` of `bus_din`. L is `(address) mod 4` for a 32-bit port, `(address) mod 2` for a 16-bit port and 0 for an 8-bit port. Bytes are assembled big-endian into `rdata`, right-justified with zero upper bytes, and `rdata` is valid when `done` is high.
- R8: On a write, the operand byte for an address sits on the lane given by the R7 rule for every port width. Lanes left of the 32-bit position carry a copy of the first remaining byte, or of its 16-bit neighbour. Only the addresses of the operand are written.
- R9: `bus_rw` is 1 for reads and 0 for writes, and holds for the whole operand.
- R10: `done` pulses for one clock, in the clock after the final acknowledge is sampled. In that clock `bus_as` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operand request, taken when `req_ready` is high |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write operand, 0 = read operand |
| req_addr | input | ADDR_W | Byte address of the operand's first byte |
| req_siz | input | 2 | Operand length, encoded as in R2 |
| req_wdata | input | 32 | Write operand, right-justified, big-endian |
| done | output | 1 | One-clock end-of-operand pulse |
| rdata | output | 32 | Assembled read operand, right-justified |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| bus_siz | output | 2 | Bytes still to move, encoded as in R2 |
| bus_rw | output | 1 | Transfer direction, 1 = read |
| bus_ecs | output | 1 | Start of every bus cycle |
| bus_ocs | output | 1 | Start of the first cycle of an operand |
| bus_as | output | 1 | Address valid |
| bus_ds | output | 1 | Data strobe |
| bus_dout | output | 32 | Write data lanes |
| bus_din | input | 32 | Read data lanes |
| bus_ack | input | 2 | Cycle acknowledge and port width, as in R3 |

## Verification
The assertions assume that the slave holds `bus_ack` at 11 whenever `bus_as` is low. They also assume that an acknowledge, once returned, is taken in a single clock, and that a request only arrives while `req_ready` is high. The bench slave acts only on clocks where it sees the address strobe, and drives 11 otherwise. The request driver raises `req_valid` for one clock when the controller is idle. Every port width is swept, along with a rotating mix of widths within one operand, every start offset and length, and zero or two wait states.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_GAP} dbs_state_t;

  // 2-bit length code to byte count (00 means four bytes)
  function automatic logic [2:0] siz_to_count(input logic [1:0] s);
    return (s == 2'b00) ? 3'd4 : {1'b0, s};
  endfunction

  // acknowledge code to port width in bytes
  function automatic logic [2:0] ack_to_port(input logic [1:0] a);
    case (a)
      2'b00:   return 3'd4;
      2'b01:   return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dbs_step.sv
module dbs_step
  import dbs_pkg::*;
(
  input  logic [1:0] addr_lo,
  input  logic [2:0] rem,
  input  logic [1:0] ack,
  output logic [2:0] moved,
  output logic [1:0] first_lane
);
  logic [2:0] port_b;
  logic [2:0] off;
  logic [2:0] cap;

  always_comb begin
    port_b = ack_to_port(ack);
    case (port_b)
      3'd4:    off = {1'b0, addr_lo};
      3'd2:    off = {2'b00, addr_lo[0]};
      default: off = 3'd0;
    endcase
    cap        = port_b - off;
    moved      = (rem < cap) ? rem : cap;
    first_lane = off[1:0];
  end
endmodule

// File: rtl/dbs_rd_merge.sv
module dbs_rd_merge
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] din,
  input  logic [1:0]        first_lane,
  input  logic [2:0]        moved,
  output logic [DATA_W-1:0] acc_next
);
  logic [5:0]        sh;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] chunk;

  always_comb begin
    sh       = 6'd32 - {1'b0, first_lane, 3'b000} - {moved, 3'b000};
    mask     = (moved == 3'd4) ? '1 : ((32'd1 << {moved, 3'b000}) - 32'd1);
    chunk    = (din >> sh) & mask;
    acc_next = (acc << {moved, 3'b000}) | chunk;
  end
endmodule

// File: rtl/dbs_wr_lanes.sv
module dbs_wr_lanes
  import dbs_pkg::*;
(
  input  logic [DATA_W-1:0] wsh,
  input  logic [1:0]        addr_lo,
  output logic [DATA_W-1:0] dout
);
  for (genvar L = 0; L < LANES; L++) begin : g_lane
    localparam logic [1:0] LB = L[1:0];
    logic [1:0] idx;
    always_comb begin
      if (LB >= addr_lo)
        idx = LB - addr_lo;
      else if (LB[0] >= addr_lo[0])
        idx = {1'b0, LB[0]} - {1'b0, addr_lo[0]};
      else
        idx = 2'd0;
    end
    assign dout[8*(LANES-1-L) +: 8] = wsh[{~idx, 3'b000} +: 8];
  end
endmodule

// File: rtl/dyn_bus_sizer.sv
module dyn_bus_sizer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_siz,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_siz,
  output logic              bus_rw,
  output logic              bus_ecs,
  output logic              bus_ocs,
  output logic              bus_as,
  output logic              bus_ds,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din,
  input  logic [1:0]        bus_ack
);
  localparam logic [1:0] ACK_WAIT = 2'b11;

  dbs_state_t        state;
  logic [ADDR_W-1:0] cur_addr;
  logic [2:0]        cur_rem;
  logic [DATA_W-1:0] wsh, rsh;
  logic              is_wr;

  logic [2:0]        req_cnt, moved, rem_nxt;
  logic [1:0]        first_lane, lane_a;
  logic [DATA_W-1:0] req_left, lane_src, lane_out, rsh_nxt, wsh_nxt;
  logic [ADDR_W-1:0] addr_nxt;
  logic              ack_ok;

  assign req_cnt  = siz_to_count(req_siz);
  assign req_left = req_wdata << (6'd32 - {req_cnt, 3'b000});
  assign ack_ok   = (state == ST_BUSY) && (bus_ack != ACK_WAIT);
  assign rem_nxt  = cur_rem - moved;
  assign addr_nxt = cur_addr + ADDR_W'(moved);
  assign wsh_nxt  = wsh << {moved, 3'b000};
  assign lane_src = (state == ST_IDLE) ? req_left : wsh;
  assign lane_a   = (state == ST_IDLE) ? req_addr[1:0] : cur_addr[1:0];

  assign req_ready = (state == ST_IDLE);
  assign bus_addr  = cur_addr;
  assign bus_siz   = cur_rem[1:0];

  dbs_step u_step (
    .addr_lo(cur_addr[1:0]), .rem(cur_rem), .ack(bus_ack),
    .moved(moved), .first_lane(first_lane)
  );

  dbs_rd_merge u_merge (
    .acc(rsh), .din(bus_din), .first_lane(first_lane), .moved(moved),
    .acc_next(rsh_nxt)
  );

  dbs_wr_lanes u_lanes (
    .wsh(lane_src), .addr_lo(lane_a), .dout(lane_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      cur_rem  <= '0;
      wsh      <= '0;
      rsh      <= '0;
      is_wr    <= 1'b0;
      done     <= 1'b0;
      rdata    <= '0;
      bus_rw   <= 1'b1;
      bus_ecs  <= 1'b0;
      bus_ocs  <= 1'b0;
      bus_as   <= 1'b0;
      bus_ds   <= 1'b0;
      bus_dout <= '0;
    end else begin
      done    <= 1'b0;
      bus_ecs <= 1'b0;
      bus_ocs <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          cur_addr <= req_addr;
          cur_rem  <= req_cnt;
          wsh      <= req_left;
          rsh      <= '0;
          is_wr    <= req_write;
          bus_rw   <= ~req_write;
          bus_dout <= lane_out;
          bus_ecs  <= 1'b1;
          bus_ocs  <= 1'b1;
          bus_as   <= 1'b1;
          bus_ds   <= 1'b1;
          state    <= ST_BUSY;
        end
        ST_BUSY: if (ack_ok) begin
          bus_as   <= 1'b0;
          bus_ds   <= 1'b0;
          cur_addr <= addr_nxt;
          cur_rem  <= rem_nxt;
          wsh      <= wsh_nxt;
          rsh      <= rsh_nxt;
          if (rem_nxt == 3'd0) begin
            done  <= 1'b1;
            if (!is_wr) rdata <= rsh_nxt;
            state <= ST_IDLE;
          end else begin
            state <= ST_GAP;
          end
        end
        ST_GAP: begin
          bus_dout <= lane_out;
          bus_ecs  <= 1'b1;
          bus_as   <= 1'b1;
          bus_ds   <= 1'b1;
          state    <= ST_BUSY;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ocs_first_R5: assert property (@(posedge clk) disable iff (rst)
    bus_ocs |-> bus_ecs);
  assert_ecs_start_R5: assert property (@(posedge clk) disable iff (rst)
    bus_ecs |-> (bus_as && !$past(bus_as)));
  assert_hold_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_as && $past(bus_as) && ($past(bus_ack) == ACK_WAIT))
      |-> ($stable(bus_addr) && $stable(bus_siz) && $stable(bus_dout)));
  assert_gap_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(bus_as) && ($past(bus_ack) != ACK_WAIT)) |-> !bus_as);
  assert_step_R4: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> ((moved != 3'd0) && (moved <= cur_rem)));
  assert_done_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(bus_as) && !bus_as && req_ready));
  assert_rw_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_as && $past(bus_as)) |-> $stable(bus_rw));
endmodule

// File: tb/tb_dyn_bus_sizer.sv
module tb_dyn_bus_sizer;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_write;
  logic [31:0] req_addr, req_wdata, rdata;
  logic [1:0]  req_siz;
  logic        done;
  logic [31:0] bus_addr, bus_dout, bus_din;
  logic [1:0]  bus_siz, bus_ack;
  logic        bus_rw, bus_ecs, bus_ocs, bus_as, bus_ds;

  always #5 clk = ~clk;

  dyn_bus_sizer #(.ADDR_W(32)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_siz(req_siz),
    .req_wdata(req_wdata), .done(done), .rdata(rdata),
    .bus_addr(bus_addr), .bus_siz(bus_siz), .bus_rw(bus_rw),
    .bus_ecs(bus_ecs), .bus_ocs(bus_ocs), .bus_as(bus_as), .bus_ds(bus_ds),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_ack(bus_ack)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] mem [0:15];

  // slave configuration, set by the request driver
  int          port_mode, wait_cyc, s_rem, s_cyc;
  bit          op_write, s_first;
  logic [31:0] s_addr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] enc(input int n);
    return (n == 4) ? 2'b00 : 2'(n);
  endfunction

  // bus slave
  initial begin
    bit prev_as = 0, acked = 0, fresh;
    int wcnt = 0;
    bus_ack = 2'b11;
    bus_din = 32'h0;
    forever begin
      @(negedge clk);
      if (rst) begin
        bus_ack = 2'b11; prev_as = 0; acked = 0;
        continue;
      end
      if (acked) begin
        chk(!bus_as, "R6 strobe low after ack", 32'(bus_as), 32'd0);
        acked = 0;
      end
      if (!bus_as) begin
        bus_ack = 2'b11;
        prev_as = 0;
      end else begin
        fresh = !prev_as;
        prev_as = 1;
        if (fresh) begin
          wcnt = 0;
          chk(bus_ecs == 1'b1, "R5 ecs at cycle start", 32'(bus_ecs), 32'd1);
          chk(bus_ocs == s_first, "R5 ocs first cycle only", 32'(bus_ocs), 32'(s_first));
          s_first = 0;
        end else begin
          chk(!bus_ecs && !bus_ocs, "R5 strobes one clock", {bus_ecs, bus_ocs}, 32'd0);
        end
        chk(bus_ds == 1'b1, "R6 ds with as", 32'(bus_ds), 32'd1);
        chk(bus_rw == !op_write, "R9 direction", 32'(bus_rw), 32'(!op_write));
        chk(bus_addr == s_addr, "R4 address", bus_addr, s_addr);
        chk(bus_siz == enc(s_rem), "R2 size code", 32'(bus_siz), 32'(enc(s_rem)));
        if (wcnt < wait_cyc) begin
          wcnt++;
          bus_ack = 2'b11;           // R3 wait state
        end else begin
          int p, off, m, lane;
          case (port_mode)
            0: p = 4;
            1: p = 2;
            2: p = 1;
            default: p = (s_cyc % 3 == 0) ? 1 : ((s_cyc % 3 == 1) ? 2 : 4);
          endcase
          off = int'(s_addr % p);
          m = (s_rem < p - off) ? s_rem : p - off;
          bus_din = 32'h5A5A5A5A;
          for (int i = 0; i < m; i++) begin
            lane = (p == 1) ? 0 : int'((s_addr + 32'(i)) % p);
            if (op_write)
              mem[(s_addr + 32'(i)) & 32'hF] = bus_dout[31-8*lane -: 8];
            else
              bus_din[31-8*lane -: 8] = mem[(s_addr + 32'(i)) & 32'hF];
          end
          bus_ack = (p == 4) ? 2'b00 : ((p == 2) ? 2'b01 : 2'b10);
          s_addr = s_addr + 32'(m);
          s_rem = s_rem - m;
          s_cyc++;
          acked = 1;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // request driver
  initial begin
    int trial = 0;
    rst = 1; req_valid = 0; req_write = 0; req_addr = 0; req_siz = 0; req_wdata = 0;
    port_mode = 0; wait_cyc = 0; s_rem = 0; s_cyc = 0; op_write = 0; s_first = 0; s_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !bus_as && !bus_ds && !bus_ecs && !bus_ocs && !done, "R1 reset state",
        {req_ready, bus_as, bus_ds, bus_ecs, bus_ocs, done}, 32'h20);
    rst = 0;
    for (int wr = 0; wr < 2; wr++)
      for (int mode = 0; mode < 4; mode++)
        for (int wt = 0; wt <= 2; wt += 2)
          for (int a = 0; a < 4; a++)
            for (int n = 1; n <= 4; n++) begin
              logic [7:0]  snap [0:15];
              logic [31:0] wd, exp;
              int base, got;
              bit ok;
              trial++;
              for (int i = 0; i < 16; i++) begin
                mem[i] = 8'((i * 37 + trial * 11) & 255);
                snap[i] = mem[i];
              end
              wd = 32'(trial) * 32'h9E3779B1 + 32'd1;
              base = 4 + a;
              @(negedge clk);
              op_write = (wr == 1); port_mode = mode; wait_cyc = wt;
              s_addr = 32'h0000_0100 + 32'(base); s_rem = n; s_first = 1; s_cyc = 0;
              req_valid = 1; req_write = (wr == 1); req_addr = s_addr - 32'h0;
              req_addr = 32'h0000_0100 + 32'(base);
              req_siz = enc(n); req_wdata = wd;
              @(posedge clk);
              @(negedge clk);
              req_valid = 0;
              got = 0;
              for (int t = 0; t < 100 && !got; t++) begin
                if (done) got = 1; else @(negedge clk);
              end
              chk(got == 1, "R10 done reached", 32'(got), 32'd1);
              chk(req_ready && !bus_as, "R10 idle at done", {req_ready, bus_as}, 32'h2);
              chk(s_rem == 0, "R4 all bytes moved", 32'(s_rem), 32'd0);
              if (wr == 0) begin
                exp = 0;
                for (int k = 0; k < n; k++) exp = (exp << 8) | 32'(snap[base + k]);
                chk(rdata == exp, "R7 read assembly", rdata, exp);
              end else begin
                ok = 1;
                for (int i = 0; i < 16; i++) begin
                  logic [7:0] e;
                  e = (i >= base && i < base + n) ? wd[8*(n-1-(i-base)) +: 8] : snap[i];
                  if (mem[i] != e) ok = 0;
                end
                chk(ok, "R8 write lanes", {mem[base], mem[base+1], mem[base+2], mem[base+3]}, wd);
              end
              @(negedge clk);
              chk(!done, "R10 done one clock", 32'(done), 32'd0);
            end
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule